// File: doc/BRIEF.md
# Two-way write-back set-associative cache

This block is a two-way set-associative data cache placed between a processor request port and a lower-level memory port. A request carries the set-selecting address bits from the virtual side and, alongside them, the physical tag produced by an external translator. The set is read with the virtual bits. Both stored tags are compared with the physical tag in the same cycle. The word from the matching way is returned, and the request completes in the cycle where the handshake signal `req_ready` is high.

On a miss the block picks a victim: an invalid way if one exists, otherwise the way the per-set recency bit marks. A dirty victim is streamed back to memory word by word. The new block is then read in word by word, and the held request completes as a hit. Writes never bypass the cache: a write miss allocates the block first and the write data is merged in afterwards.

Top module: `twoway_wb_cache`

## Requirements
- R1: A read whose physical tag matches a valid way of the indexed set completes with `req_ready` high in the same cycle as the request, with no memory beat, and returns the stored word from that way.
- R2: Two blocks with the same index and different tags are held at once, one per way, and both then hit. At most one way ever matches.
- R3: A write hit changes only the cached word and marks the block dirty. It causes no memory beat, and a later read returns the new word.
- R4: When the victim is valid and dirty, the full block is written to memory at its old address before any beat of the refill. A later miss on that block returns the written data.
- R5: When the victim is clean, no write beat is issued; the refill alone is performed.
- R6: A write miss reads the whole block from memory, then merges the write word. The written word and the untouched words of that block are both read back correctly.
- R7: Each set keeps one recency bit that is updated on every hit and every fill so that it points to the way not just used. A miss replaces an invalid way first, otherwise the way that bit selects.
- R8: During a miss sequence `req_ready` stays low. A pending miss starts memory beats in the next cycle. A beat with `mem_ready` low holds its address and direction until it is accepted.
- R9: After reset every block is invalid: with no request the memory port is idle, and the first access to any address misses.
- R10: Every memory beat uses the byte address {tag, index, word number, zero byte bits}. The index comes from `req_vaddr` and the refill tag from `req_ptag`. Beats run from word 0 upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; held with its fields until accepted |
| req_we | input | 1 | 1 = write, 0 = read |
| req_vaddr | input | IDX_W+WO_W | Virtual address bits above the byte offset: {set index, word in block} |
| req_ptag | input | TAG_W | Physical tag from translation |
| req_wdata | input | WORD_W | Write word |
| req_ready | output | 1 | Request completes this cycle (cache idle and lookup hits) |
| req_rdata | output | WORD_W | Read word, valid while req_ready is high |
| mem_valid | output | 1 | Memory beat requested |
| mem_we | output | 1 | 1 = writeback beat, 0 = refill beat |
| mem_addr | output | PA_W | Byte address of the beat's word |
| mem_wdata | output | WORD_W | Writeback word |
| mem_ready | input | 1 | Beat accepted this cycle |
| mem_rdata | input | WORD_W | Refill word, valid in the accepting cycle |

## Verification
The bench fills one set with a chain of conflicting tags, so clean evictions (reads only) can be told apart from dirty evictions (full writeback, then refill). The victim choice shows whether the recency bit followed the last hit or the last fill. Repeated accesses to resident blocks must produce zero beats, which separates true hits from silent refills. A write miss followed by reads of the written and unwritten words tells merge-after-fill apart from fill-overwrites-write. Reads of one physical tag under two virtual indexes check that index and tag are taken from separate inputs. Memory acceptance stalls every third cycle, so the address-hold rule is exercised on both beat directions.

// File: rtl/twoway_wb_cache.sv
module twoway_wb_cache #(
  parameter int PA_W      = 44,
  parameter int WORD_W    = 32,
  parameter int BLK_WORDS = 16,
  parameter int SETS      = 64,
  localparam int WB_W  = $clog2(WORD_W/8),
  localparam int WO_W  = $clog2(BLK_WORDS),
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = PA_W - WB_W - WO_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [IDX_W+WO_W-1:0] req_vaddr,
  input  logic [TAG_W-1:0]  req_ptag,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              req_ready,
  output logic [WORD_W-1:0] req_rdata,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [PA_W-1:0]   mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [WORD_W-1:0] mem_rdata
);

  typedef enum logic [1:0] {S_IDLE, S_WB, S_FILL} st_t;
  st_t st;

  logic [SETS-1:0]   vld [2];
  logic [SETS-1:0]   dty [2];
  logic [SETS-1:0]   lru;
  logic [TAG_W-1:0]  tg  [2][SETS];
  logic [WORD_W-1:0] dat [2][SETS*BLK_WORDS];

  logic [IDX_W-1:0] idx, m_idx;
  logic [WO_W-1:0]  wo, cnt;
  logic [TAG_W-1:0] m_tag;
  logic [1:0]       hit_w;
  logic             hit, hway, vway, m_way, last;

  assign idx = req_vaddr[WO_W +: IDX_W];
  assign wo  = req_vaddr[WO_W-1:0];

  for (genvar w = 0; w < 2; w++) begin : g_cmp
    assign hit_w[w] = vld[w][idx] && (tg[w][idx] == req_ptag);
  end

  assign hit  = |hit_w;
  assign hway = hit_w[1];
  assign vway = !vld[0][idx] ? 1'b0 : !vld[1][idx] ? 1'b1 : lru[idx];
  assign last = &cnt;

  assign req_ready = (st == S_IDLE) && hit;
  assign req_rdata = dat[hway][{idx, wo}];

  assign mem_valid = (st != S_IDLE);
  assign mem_we    = (st == S_WB);
  assign mem_addr  = {(st == S_WB) ? tg[m_way][m_idx] : m_tag, m_idx, cnt, {WB_W{1'b0}}};
  assign mem_wdata = dat[m_way][{m_idx, cnt}];

  always_ff @(posedge clk) begin
    if (req_valid && req_ready && req_we)
      dat[hway][{idx, wo}] <= req_wdata;
    if (st == S_FILL && mem_ready) begin
      dat[m_way][{m_idx, cnt}] <= mem_rdata;
      if (last) tg[m_way][m_idx] <= m_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      vld[0] <= '0;
      vld[1] <= '0;
      dty[0] <= '0;
      dty[1] <= '0;
      lru    <= '0;
      cnt    <= '0;
      m_way  <= 1'b0;
      m_idx  <= '0;
      m_tag  <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (req_valid && hit) begin
            lru[idx] <= ~hway;
            if (req_we) dty[hway][idx] <= 1'b1;
          end else if (req_valid) begin
            m_way <= vway;
            m_idx <= idx;
            m_tag <= req_ptag;
            cnt   <= '0;
            st    <= (vld[vway][idx] && dty[vway][idx]) ? S_WB : S_FILL;
          end
        S_WB:
          if (mem_ready) begin
            cnt <= cnt + 1'b1;
            if (last) st <= S_FILL;
          end
        S_FILL:
          if (mem_ready) begin
            cnt <= cnt + 1'b1;
            if (last) begin
              vld[m_way][m_idx] <= 1'b1;
              dty[m_way][m_idx] <= 1'b0;
              lru[m_idx]        <= ~m_way;
              st                <= S_IDLE;
            end
          end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/twoway_wb_cache_chk.sv
module twoway_wb_cache_chk #(
  parameter int PA_W = 44,
  parameter int WB_W = 2,
  parameter int WO_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [1:0]      hit_w,
  input logic            mem_valid,
  input logic            mem_we,
  input logic            mem_ready,
  input logic [PA_W-1:0] mem_addr
);

  AST_ONE_WAY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_w[0] && hit_w[1])); // R2

  AST_NO_READY_IN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !req_ready); // R8

  AST_MISS_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !mem_valid) |=> mem_valid); // R8

  AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we))); // R8

  AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we && mem_ready && (&mem_addr[WB_W +: WO_W])) |=> (mem_valid && !mem_we)); // R4

endmodule

bind twoway_wb_cache twoway_wb_cache_chk #(.PA_W(PA_W), .WB_W(WB_W), .WO_W(WO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .hit_w(hit_w),
  .mem_valid(mem_valid), .mem_we(mem_we), .mem_ready(mem_ready), .mem_addr(mem_addr));

// File: tb/twoway_wb_cache_test.sv
module twoway_wb_cache_test;
  localparam int PA_W = 44, WORD_W = 32, BW = 4, SETS = 4;
  localparam int WB_W = 2, WO_W = 2, IDX_W = 2;
  localparam int TAG_W = PA_W - WB_W - WO_W - IDX_W;
  localparam int KEY_W = PA_W - WB_W;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0;
  logic [IDX_W+WO_W-1:0] req_vaddr = '0;
  logic [TAG_W-1:0] req_ptag = '0;
  logic [WORD_W-1:0] req_wdata = '0, req_rdata, mem_wdata, mem_rdata;
  logic req_ready, mem_valid, mem_we, mem_ready;
  logic [PA_W-1:0] mem_addr;

  always #5 clk = ~clk;

  twoway_wb_cache #(.PA_W(PA_W), .WORD_W(WORD_W), .BLK_WORDS(BW), .SETS(SETS)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we), .req_vaddr(req_vaddr),
    .req_ptag(req_ptag), .req_wdata(req_wdata), .req_ready(req_ready), .req_rdata(req_rdata),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata));

  logic [WORD_W-1:0] bmem [logic [KEY_W-1:0]];
  logic [WORD_W-1:0] rmem [logic [KEY_W-1:0]];

  function automatic logic [WORD_W-1:0] pat(input logic [KEY_W-1:0] k);
    return {k[29:0], 2'b01} ^ 32'h3C00_0000;
  endfunction

  logic [KEY_W-1:0] mkey;
  assign mkey = mem_addr[PA_W-1:WB_W];
  assign mem_rdata = bmem.exists(mkey) ? bmem[mkey] : pat(mkey);

  logic [1:0] stall = 0;
  always @(negedge clk) stall <= (stall == 2) ? 2'd0 : stall + 1'b1;
  assign mem_ready = (stall != 0);

  int n_wr = 0, n_rd = 0;
  bit order_bad = 0, seq_bad = 0, hold_bad = 0, rdy_bad = 0, pend = 0;
  logic [KEY_W-1:0] wb_key = '0, rd_key = '0, pend_addr = '0;

  always @(posedge clk) begin
    if (pend && (!mem_valid || mkey != pend_addr)) hold_bad <= 1;
    pend      <= mem_valid && !mem_ready;
    pend_addr <= mkey;
    if (mem_valid && req_ready) rdy_bad <= 1;
    if (mem_valid && mem_ready) begin
      if (mem_we) begin
        bmem[mkey] = mem_wdata;
        if (mkey[WO_W-1:0] != WO_W'(n_wr)) seq_bad <= 1;
        if (mkey[WO_W-1:0] == 0) wb_key <= mkey;
        n_wr <= n_wr + 1;
      end else begin
        if (mkey[WO_W-1:0] != WO_W'(n_rd)) seq_bad <= 1;
        if (mkey[WO_W-1:0] == 0) rd_key <= mkey;
        n_rd <= n_rd + 1;
      end
    end
  end

  int n_chk = 0, n_err = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [KEY_W-1:0] key(input logic [TAG_W-1:0] t, input int s, input int w);
    return {t, IDX_W'(s), WO_W'(w)};
  endfunction

  function automatic logic [WORD_W-1:0] rget(input logic [KEY_W-1:0] k);
    return rmem.exists(k) ? rmem[k] : pat(k);
  endfunction

  int nwr, nrd, wt;
  logic [WORD_W-1:0] rd;

  task automatic access(input bit we, input logic [TAG_W-1:0] t, input int s, input int w,
                        input logic [WORD_W-1:0] wd);
    int w0, r0;
    w0 = n_wr; r0 = n_rd; wt = 0;
    if (n_wr % BW != 0 || n_rd % BW != 0) seq_bad = 1;
    n_wr = 0; n_rd = 0; w0 = 0; r0 = 0;
    @(negedge clk);
    req_valid = 1; req_we = we; req_ptag = t; req_wdata = wd;
    req_vaddr = {IDX_W'(s), WO_W'(w)};
    forever begin
      #1;
      if (req_ready) break;
      @(negedge clk);
      wt++;
    end
    rd = req_rdata;
    if (we) rmem[key(t, s, w)] = wd;
    @(posedge clk);
    #1;
    req_valid = 0;
    nwr = n_wr - w0; nrd = n_rd - r0;
  endtask

  localparam logic [TAG_W-1:0] TA = 5, TB = 9, TC = 13, TD = 17, TE = 21, TF = 25, TG = 3;

  task automatic t_reset;
    @(negedge clk);
    chk("R9", "mem_valid idle after reset", mem_valid, 0);
    chk("R9", "req_ready low after reset", req_ready, 0);
  endtask

  task automatic t_first_miss;
    access(0, TA, 0, 1, 0);
    chk("R9", "first access refill beats", nrd, BW);
    chk("R9", "first access writeback beats", nwr, 0);
    chk("R1", "miss read data", rd, rget(key(TA, 0, 1)));
    chk("R8", "ready held low for refill", wt >= BW, 1);
    chk("R10", "refill base address", rd_key, key(TA, 0, 0));
  endtask

  task automatic t_read_hit;
    access(0, TA, 0, 3, 0);
    chk("R1", "hit beats", nrd + nwr, 0);
    chk("R1", "hit same cycle", wt, 0);
    chk("R1", "hit data", rd, rget(key(TA, 0, 3)));
  endtask

  task automatic t_two_ways;
    access(0, TB, 0, 0, 0);
    chk("R2", "second tag refills", nrd, BW);
    access(0, TA, 0, 1, 0);
    chk("R2", "first tag still hits", nrd + nwr, 0);
    chk("R2", "first tag data", rd, rget(key(TA, 0, 1)));
    access(0, TB, 0, 2, 0);
    chk("R2", "second tag hits", nrd + nwr, 0);
    chk("R2", "second tag data", rd, rget(key(TB, 0, 2)));
  endtask

  task automatic t_write_hit;
    access(1, TA, 0, 1, 32'hCAFE_0001);
    chk("R3", "write hit beats", nrd + nwr, 0);
    access(0, TA, 0, 1, 0);
    chk("R3", "write hit readback", rd, 32'hCAFE_0001);
    chk("R3", "readback beats", nrd + nwr, 0);
  endtask

  task automatic t_lru_and_evict;
    access(0, TC, 0, 0, 0);
    chk("R5", "clean victim no writeback", nwr, 0);
    chk("R5", "clean victim refill", nrd, BW);
    access(0, TA, 0, 1, 0);
    chk("R7", "recent way kept", nrd + nwr, 0);
    chk("R7", "recent way data", rd, 32'hCAFE_0001);
    access(0, TD, 0, 2, 0);
    chk("R7", "victim follows last hit", nwr, 0);
    access(0, TE, 0, 3, 0);
    chk("R4", "dirty victim writeback beats", nwr, BW);
    chk("R4", "refill after writeback", nrd, BW);
    chk("R4", "no refill beat before writeback done", order_bad, 0);
    chk("R4", "writeback address uses old tag", wb_key, key(TA, 0, 0));
    chk("R7", "fill points recency away", rd, rget(key(TE, 0, 3)));
    access(0, TA, 0, 1, 0);
    chk("R4", "written data survives eviction", rd, 32'hCAFE_0001);
    chk("R7", "victim after fill is clean other way", nwr, 0);
  endtask

  task automatic t_write_miss;
    access(1, TF, 1, 2, 32'h1234_5678);
    chk("R6", "write miss refill", nrd, BW);
    chk("R6", "write miss no writeback", nwr, 0);
    access(0, TF, 1, 2, 0);
    chk("R6", "merged word", rd, 32'h1234_5678);
    access(0, TF, 1, 0, 0);
    chk("R6", "untouched word", rd, rget(key(TF, 1, 0)));
    chk("R6", "reads after allocate hit", nrd + nwr, 0);
  endtask

  task automatic t_index;
    access(0, TG, 2, 1, 0);
    chk("R10", "index 2 data", rd, rget(key(TG, 2, 1)));
    chk("R10", "index 2 refill address", rd_key, key(TG, 2, 0));
    access(0, TG, 3, 1, 0);
    chk("R10", "index 3 data", rd, rget(key(TG, 3, 1)));
    chk("R10", "index 3 refill address", rd_key, key(TG, 3, 0));
    chk("R10", "beats ascending", seq_bad, 0);
    chk("R8", "beat held while stalled", hold_bad, 0);
    chk("R8", "ready low during miss", rdy_bad, 0);
  endtask

  always @(posedge clk) if (mem_valid && mem_ready && !mem_we && n_rd == 0 && n_wr % BW != 0) order_bad <= 1;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_first_miss();
    t_read_hit();
    t_two_ways();
    t_write_hit();
    t_lru_and_evict();
    t_write_miss();
    t_index();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule